// File: doc/BRIEF.md
# Port Activity Tracker and Conditional-Search Qualifier

This block keeps the per-channel state of an eight-channel open-drain I/O port and decides whether the device should answer a conditional search. It holds the output latch that drives the port transistors (a 1 turns a transistor off), a sticky activity flag per channel, and three configuration bytes: a channel mask, a polarity byte and a control/status byte. The serial bus front end and the command decoder sit outside. They reach this unit through a byte-wide register write port, an output-load strobe, a clear-activity pulse and the level of the external reset/strobe pin.

The raw pin levels pass through a two-flop synchronizer. A channel's activity flag sets whenever its synchronized level differs from its value one clock earlier. The search qualifier compares the masked channels against the polarity byte. It takes each channel either from the pin or from the activity flag, and it combines the channels with an AND or an OR term. A sticky power-on flag forces a positive answer until software clears it.

Top module: `pio_search_unit`

## Requirements
- R1: After power-on reset (`porN` low): mask = 00h, polarity = 00h, output latch = FFh, activity = 00h, control/status bits 0 to 2 = 0, bit 3 (power-on flag) = 1, and `searchHit` = 1.
- R2: A rise or a fall on a pin sets that channel's activity bit. The bit is visible three clock edges after the pin changes and stays set until it is cleared.
- R3: Pins are wired-AND with the output latch. Loading an output value that pulls a high pin low therefore sets that channel's activity bit.
- R4: A `clrAct` pulse clears every activity bit on the next edge. A clear in the same cycle as a detected change wins over the set.
- R5: While control bit 2 = 0 (reset-pin mode), `rstPinN` low sets the output latch to all ones and clears all activity bits. While bit 2 = 1, `rstPinN` has no effect.
- R6: A register write with `wrEn` lands in the mask at address 008Bh, in the polarity byte at 008Ch and in control/status at 008Dh. Writes to any other address change nothing.
- R7: Control/status reads {bit7 = `vccPresent`, bits 6 to 4 = 000, bit3 = power-on flag, bit2 = pin mode, bit1 = term (0 OR, 1 AND), bit0 = source (0 pins, 1 activity)}. Bits 7 to 4 cannot be written.
- R8: Writing 0 to control bit 3 clears the power-on flag, and writing 1 leaves it unchanged. While the flag is 1, `searchHit` is 1.
- R9: A channel takes part only if its mask bit is 1. It matches when its source bit (the synchronized pin or the activity bit, chosen by control bit 0) equals its polarity bit.
- R10: In OR mode `searchHit` is 1 if any participating channel matches. In AND mode every participating channel must match. With an empty mask both terms are 0.
- R11: `outWrEn` loads `outWrData` into the output latch on the next edge, unless the reset pin forces the latch off in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| pinIn | input | 8 | Raw pin levels, asynchronous |
| rstPinN | input | 1 | Synchronized level of the reset/strobe pin |
| vccPresent | input | 1 | External supply status |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 16 | Register write address |
| wrData | input | 8 | Register write data |
| outWrEn | input | 1 | Output latch load strobe |
| outWrData | input | 8 | New output latch value |
| clrAct | input | 1 | Clear-all-activity pulse |
| pinState | output | 8 | Synchronized pin levels |
| outLatch | output | 8 | Output latch |
| actLatch | output | 8 | Activity latches |
| selMask | output | 8 | Channel mask register |
| polarity | output | 8 | Polarity register |
| ctrlStat | output | 8 | Control/status register |
| searchHit | output | 1 | Conditional-search response |

## Verification
The bench models each pin as the external level wired-AND with the output latch. It then checks that output loads and reset-pin events set activity on exactly the channels whose level moves. A design that compared latch values instead of pin levels would flag channels held low from outside. The bench also writes 1 to the power-on bit after clearing it, writes to 008Ah and 008Eh, and selects an empty mask in both combine modes. A wrong design would set the flag again, corrupt a neighbouring register, or answer a search with no channels selected. Random sequences mix all operations, including reset-pin pulses in both pin modes, against a reference model.

// File: rtl/pio_search_pkg.sv
package pio_search_pkg;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic wrMask;
    logic wrPol;
    logic wrCtrl;
    logic loadOut;
    logic clrAct;
    logic forceOff;
  } pio_strobe_t;

  // Control/status bit positions
  localparam int CTRL_SRC  = 0;
  localparam int CTRL_TERM = 1;
  localparam int CTRL_ROS  = 2;
  localparam int CTRL_POR  = 3;
  localparam int CTRL_VCC  = 7;

endpackage

// File: rtl/pio_search_ctrl.sv
module pio_search_ctrl
  import pio_search_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h8B
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              outWrEn,
  input  logic              clrActReq,
  input  logic              rstPinN,
  input  logic              rosMode,
  output pio_strobe_t       strobe
);
  localparam logic [ADDR_W-1:0] POL_ADDR  = MASK_ADDR + 1'b1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = MASK_ADDR + 2'd2;

  logic pinReset;

  always_comb begin
    pinReset        = !rstPinN && !rosMode;
    strobe.wrMask   = wrEn && (wrAddr == MASK_ADDR);
    strobe.wrPol    = wrEn && (wrAddr == POL_ADDR);
    strobe.wrCtrl   = wrEn && (wrAddr == CTRL_ADDR);
    strobe.loadOut  = outWrEn && !pinReset;
    strobe.forceOff = pinReset;
    strobe.clrAct   = clrActReq || pinReset;
  end
endmodule

// File: rtl/pio_search_dp.sv
module pio_search_dp
  import pio_search_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              porN,
  input  logic [NUM_CH-1:0] pinIn,
  input  pio_strobe_t       strobe,
  input  logic [7:0]        wrData,
  input  logic [NUM_CH-1:0] outWrData,
  input  logic              vccPresent,
  output logic [NUM_CH-1:0] pinState,
  output logic [NUM_CH-1:0] outLatch,
  output logic [NUM_CH-1:0] actLatch,
  output logic [NUM_CH-1:0] selMask,
  output logic [NUM_CH-1:0] polarity,
  output logic [7:0]        ctrlStat,
  output logic              rosMode,
  output logic              searchHit
);
  logic [NUM_CH-1:0] syncA, syncB, syncPrev;
  logic [NUM_CH-1:0] pinEdge, srcBits, matchBits;
  logic [2:0]        modeBits;
  logic              porFlag, anyHit, allHit;

  // Synchronizer and previous-value register, no reset so they settle during reset
  always_ff @(posedge clk) begin
    syncA    <= pinIn;
    syncB    <= syncA;
    syncPrev <= syncB;
  end

  assign pinEdge  = syncB ^ syncPrev;
  assign pinState = syncB;

  // Per-channel activity latch
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_act
    always_ff @(posedge clk or negedge porN) begin
      if (!porN)              actLatch[ch] <= 1'b0;
      else if (strobe.clrAct) actLatch[ch] <= 1'b0;
      else if (pinEdge[ch])   actLatch[ch] <= 1'b1;
    end
  end

  // Output latch
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                outLatch <= '1;
    else if (strobe.forceOff) outLatch <= '1;
    else if (strobe.loadOut)  outLatch <= outWrData;
  end

  // Configuration registers
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      selMask  <= '0;
      polarity <= '0;
      modeBits <= '0;
      porFlag  <= 1'b1;
    end else begin
      if (strobe.wrMask) selMask  <= wrData[NUM_CH-1:0];
      if (strobe.wrPol)  polarity <= wrData[NUM_CH-1:0];
      if (strobe.wrCtrl) begin
        modeBits <= wrData[2:0];
        porFlag  <= porFlag & wrData[CTRL_POR];
      end
    end
  end

  assign ctrlStat = {vccPresent, 3'b000, porFlag, modeBits};
  assign rosMode  = modeBits[CTRL_ROS];

  // Qualifier: per-channel match, then parallel AND / OR trees
  assign srcBits   = modeBits[CTRL_SRC] ? actLatch : syncB;
  assign matchBits = ~(srcBits ^ polarity);
  assign anyHit    = |(selMask & matchBits);
  assign allHit    = (|selMask) && (&(matchBits | ~selMask));
  assign searchHit = porFlag || (modeBits[CTRL_TERM] ? allHit : anyHit);
endmodule

// File: rtl/pio_search_unit.sv
module pio_search_unit
  import pio_search_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              porN,
  input  logic [NUM_CH-1:0] pinIn,
  input  logic              rstPinN,
  input  logic              vccPresent,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              outWrEn,
  input  logic [NUM_CH-1:0] outWrData,
  input  logic              clrAct,
  output logic [NUM_CH-1:0] pinState,
  output logic [NUM_CH-1:0] outLatch,
  output logic [NUM_CH-1:0] actLatch,
  output logic [NUM_CH-1:0] selMask,
  output logic [NUM_CH-1:0] polarity,
  output logic [7:0]        ctrlStat,
  output logic              searchHit
);
  pio_strobe_t strobe;
  logic        rosMode;

  pio_search_ctrl #(.ADDR_W(ADDR_W), .MASK_ADDR(ADDR_W'('h8B))) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .outWrEn(outWrEn), .clrActReq(clrAct),
    .rstPinN(rstPinN), .rosMode(rosMode), .strobe(strobe)
  );

  pio_search_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .porN(porN), .pinIn(pinIn), .strobe(strobe), .wrData(wrData),
    .outWrData(outWrData), .vccPresent(vccPresent), .pinState(pinState),
    .outLatch(outLatch), .actLatch(actLatch), .selMask(selMask),
    .polarity(polarity), .ctrlStat(ctrlStat), .rosMode(rosMode),
    .searchHit(searchHit)
  );
endmodule

// File: rtl/pio_search_unit_chk.sv
module pio_search_unit_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              porN,
  input logic              rstPinN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              clrAct,
  input logic [NUM_CH-1:0] outLatch,
  input logic [NUM_CH-1:0] actLatch,
  input logic [NUM_CH-1:0] selMask,
  input logic [NUM_CH-1:0] polarity,
  input logic [7:0]        ctrlStat,
  input logic              searchHit
);
  logic pinReset, outOfRange;
  assign pinReset   = !rstPinN && !ctrlStat[2];
  assign outOfRange = wrEn && (wrAddr != ADDR_W'('h8B)) && (wrAddr != ADDR_W'('h8C));

  p_clear_act_r4: assert property (@(posedge clk) disable iff (!porN)
    clrAct |=> (actLatch == '0));

  p_pin_reset_r5: assert property (@(posedge clk) disable iff (!porN)
    pinReset |=> (outLatch == '1) && (actLatch == '0));

  p_act_sticky_r2: assert property (@(posedge clk) disable iff (!porN)
    !(clrAct || pinReset) |=> ((actLatch & $past(actLatch)) == $past(actLatch)));

  p_por_no_set_r8: assert property (@(posedge clk) disable iff (!porN)
    !ctrlStat[3] |=> !ctrlStat[3]);

  p_por_forces_hit_r8: assert property (@(posedge clk) disable iff (!porN)
    ctrlStat[3] |-> searchHit);

  p_zero_bits_r7: assert property (@(posedge clk) disable iff (!porN)
    ctrlStat[6:4] == 3'b000);

  p_empty_mask_r10: assert property (@(posedge clk) disable iff (!porN)
    (selMask == '0) && !ctrlStat[3] |-> !searchHit);

  p_ignored_write_r6: assert property (@(posedge clk) disable iff (!porN)
    outOfRange |=> $stable(selMask) && $stable(polarity));
endmodule

bind pio_search_unit pio_search_unit_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .porN(porN), .rstPinN(rstPinN), .wrEn(wrEn), .wrAddr(wrAddr),
  .clrAct(clrAct), .outLatch(outLatch), .actLatch(actLatch), .selMask(selMask),
  .polarity(polarity), .ctrlStat(ctrlStat), .searchHit(searchHit)
);

// File: tb/test_pio_search_unit.sv
`timescale 1ns/1ps
module test_pio_search_unit;
  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic [7:0]  extLevel = 8'hFF;
  logic        rstPinN = 1'b1;
  logic        vccPresent = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        outWrEn = 1'b0;
  logic [7:0]  outWrData = '0;
  logic        clrAct = 1'b0;
  logic [7:0]  pinIn, pinState, outLatch, actLatch, selMask, polarity, ctrlStat;
  logic        searchHit;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  // Reference model state
  logic [7:0] expMask = 8'h00, expPol = 8'h00, expOut = 8'hFF, expAct = 8'h00;
  logic [2:0] expMode = 3'b000;
  logic       expPor = 1'b1;

  always #2 clk = ~clk;

  assign pinIn = extLevel & outLatch;

  pio_search_unit i_pio_search_unit (
    .clk(clk), .porN(porN), .pinIn(pinIn), .rstPinN(rstPinN),
    .vccPresent(vccPresent), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .outWrEn(outWrEn), .outWrData(outWrData), .clrAct(clrAct),
    .pinState(pinState), .outLatch(outLatch), .actLatch(actLatch),
    .selMask(selMask), .polarity(polarity), .ctrlStat(ctrlStat),
    .searchHit(searchHit)
  );

  function automatic logic hitModel(input logic [7:0] mask, pol, src,
                                    input logic term, por);
    logic [7:0] m;
    m = ~(src ^ pol);
    if (por) return 1'b1;
    if (mask == 8'h00) return 1'b0;
    if (term) return ((m | ~mask) == 8'hFF);
    return ((mask & m) != 8'h00);
  endfunction

  function automatic logic [7:0] pinModel();
    return extLevel & expOut;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic checkAll();
    logic [7:0] src;
    src = expMode[0] ? expAct : pinModel();
    check("R6 mask", selMask, expMask);
    check("R6 polarity", polarity, expPol);
    check("R7 ctrl", ctrlStat, {vccPresent, 3'b000, expPor, expMode});
    check("R11 out", outLatch, expOut);
    check("R2 activity", actLatch, expAct);
    check("R9 hit", {7'b0, searchHit},
          {7'b0, hitModel(expMask, expPol, src, expMode[1], expPor)});
  endtask

  task automatic settle(input logic [7:0] oldPin);
    repeat (5) @(negedge clk);
    expAct = expAct | (oldPin ^ pinModel());
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] p;
    p = pinModel();
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    if (a == 16'h008B) expMask = d;
    if (a == 16'h008C) expPol = d;
    if (a == 16'h008D) begin expMode = d[2:0]; expPor = expPor & d[3]; end
    settle(p);
  endtask

  task automatic doLoad(input logic [7:0] d);
    logic [7:0] p;
    p = pinModel();
    @(negedge clk); outWrEn = 1'b1; outWrData = d;
    @(negedge clk); outWrEn = 1'b0;
    expOut = d;
    settle(p);
  endtask

  task automatic doExt(input logic [7:0] d);
    logic [7:0] p;
    p = pinModel();
    @(negedge clk); extLevel = d;
    settle(p);
  endtask

  task automatic doClear();
    logic [7:0] p;
    p = pinModel();
    @(negedge clk); clrAct = 1'b1;
    @(negedge clk); clrAct = 1'b0;
    expAct = 8'h00;
    settle(p);
  endtask

  task automatic doRstPin();
    logic [7:0] p;
    p = pinModel();
    @(negedge clk); rstPinN = 1'b0;
    @(negedge clk); rstPinN = 1'b1;
    if (!expMode[2]) begin expOut = 8'hFF; expAct = 8'h00; end
    settle(p);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0408));
    repeat (5) @(negedge clk);
    porN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    check("R1 mask", selMask, 8'h00);
    check("R1 polarity", polarity, 8'h00);
    check("R1 out", outLatch, 8'hFF);
    check("R1 act", actLatch, 8'h00);
    check("R1 ctrl", ctrlStat, 8'h08);
    check("R1 hit", {7'b0, searchHit}, 8'h01);

    // R7: supply bit follows input, upper bits not writable
    vccPresent = 1'b1;
    doWrite(16'h008D, 8'hF8);
    check("R7 ctrl upper", ctrlStat, 8'h88);

    // R8: clear flag, then a write of 1 leaves it cleared
    doWrite(16'h008D, 8'h00);
    check("R8 flag cleared", ctrlStat, 8'h80);
    check("R10 empty mask OR", {7'b0, searchHit}, 8'h00);
    doWrite(16'h008D, 8'h0A);
    check("R8 flag stays 0", ctrlStat, 8'h82);
    check("R10 empty mask AND", {7'b0, searchHit}, 8'h00);

    // R10: OR vs AND on pins (all high)
    doWrite(16'h008B, 8'h03);
    doWrite(16'h008C, 8'h01);
    doWrite(16'h008D, 8'h00);
    check("R10 OR one match", {7'b0, searchHit}, 8'h01);
    doWrite(16'h008D, 8'h02);
    check("R10 AND partial", {7'b0, searchHit}, 8'h00);
    doWrite(16'h008C, 8'h03);
    check("R10 AND all", {7'b0, searchHit}, 8'h01);

    // R9: source select activity latches, unmasked channel ignored
    doWrite(16'h008B, 8'h01);
    doWrite(16'h008C, 8'h01);
    doWrite(16'h008D, 8'h01);
    doClear();
    check("R4 cleared", actLatch, 8'h00);
    check("R9 act src zero", {7'b0, searchHit}, 8'h00);
    doExt(8'hFE);
    check("R2 fall sets", actLatch, 8'h01);
    check("R9 act src one", {7'b0, searchHit}, 8'h01);
    doExt(8'hFD);
    check("R2 rise and fall", actLatch, 8'h03);

    // R3: output load pulling pin low
    doExt(8'hFF);
    doClear();
    doLoad(8'hFB);
    check("R3 load sets act", actLatch, 8'h04);
    check("R11 out loaded", outLatch, 8'hFB);
    doExt(8'hFB);
    check("R3 no change no act", actLatch, 8'h04);

    // R5: reset pin in strobe mode ignored, in reset mode forces off
    doWrite(16'h008D, 8'h04);
    doRstPin();
    check("R5 strobe mode out", outLatch, 8'hFB);
    check("R5 strobe mode act", actLatch, 8'h04);
    doWrite(16'h008D, 8'h00);
    doExt(8'hFF);
    doRstPin();
    check("R5 forced off", outLatch, 8'hFF);
    check("R5 act after force", actLatch, 8'h04);

    // R6: out-of-range writes ignored
    doWrite(16'h008A, 8'h55);
    doWrite(16'h008E, 8'hAA);
    doWrite(16'h018B, 8'h77);
    checkAll();

    // Random mix
    for (int i = 0; i < 300; i++) begin
      case ($urandom_range(0, 6))
        0, 1: doWrite(16'h0089 + 16'($urandom_range(0, 6)), 8'($urandom));
        2: doLoad(8'($urandom));
        3: doExt(8'($urandom));
        4: doClear();
        5: doRstPin();
        default: begin vccPresent = 1'($urandom); @(negedge clk); end
      endcase
      checkAll();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule